// File: doc/BRIEF.md
# Recirculating Octal Line Buffer Register

The block stores one row of characters for a character-cell display. It holds a row as eight parallel one-bit shift lanes of equal depth. A shift strobe moves every lane forward by one stage, which advances a whole byte-wide character column at once. While the row is being filled, the recirculate control is low and each shift takes the byte on `data_i` into the first stage. Once the row is complete, recirculate is raised. From then on the input byte is ignored and each lane's last stage is fed back into its first. The same row can therefore be replayed once for every scan line of a character.

The output byte is always the content of the last stage of the eight lanes. A separate release control drives `oe_o`, an active-high enable for a shared bus. Release does not interact with shifting or recirculation. A build parameter removes the release control, and the enable is then tied active. Storage is static: contents are kept for as long as no shift is requested.

Top module: `lb_line_buffer`

## Requirements
- R1: An active-low `rst_ni` clears every stored bit to zero asynchronously. Until the next load, `data_o` reads 0 and every recirculated column is 0.
- R2: When `shift_i`=1 and `recirc_i`=0 on a rising clock edge, the byte on `data_i` enters the first stage and all stages advance. A byte taken on shift n appears on `data_o` after shift n+DEPTH-1.
- R3: When `shift_i`=1 and `recirc_i`=1, `data_i` is ignored and each lane's last stage is written into its first stage. After exactly DEPTH such shifts the contents, and so the output sequence, are the same as before them.
- R4: While `shift_i`=0, the stored contents and `data_o` stay unchanged for any number of cycles, whatever `data_i` and `recirc_i` do.
- R5: With the release control built in, `oe_o` is the inverse of `osel_i`: `osel_i`=1 releases the bus (`oe_o`=0). This holds combinationally and also during reset.
- R6: `osel_i` has no effect on shifting, loading or recirculation, and `recirc_i` has no effect on `oe_o`.
- R7: With HAS_OSEL=0, `oe_o` is always 1 and `osel_i` is ignored.
- R8: The eight lanes are independent. Bit k of `data_i` only ever reaches bit k of `data_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the storage |
| shift_i | input | 1 | Advance all lanes by one stage on this edge |
| recirc_i | input | 1 | 1: feed last stage back to first; 0: take data_i |
| osel_i | input | 1 | 1: release the output bus |
| data_i | input | NUM_LANES | Byte loaded into the first stage |
| data_o | output | NUM_LANES | Contents of the last stage of every lane |
| oe_o | output | 1 | Active-high output enable for the shared bus |

## Verification
A recirculating shift and a change of the bus release control can fall in the same cycle. So can a recirculating shift and a new value on the data input that must be ignored. The bench drives random bytes on `data_i` and toggles `osel_i` on most cycles while recirculating for several full passes. It also inserts partial reloads in between. Each cycle it judges `data_o` against a reference queue that rotates or loads according to `recirc_i`, and it judges `oe_o` against the inverse of `osel_i` in that same cycle.

// File: rtl/lb_pkg.sv
package lb_pkg;
  typedef enum logic {
    LB_LOAD   = 1'b0,
    LB_RECIRC = 1'b1
  } lb_mode_e;
endpackage

// File: rtl/lb_ctrl.sv
module lb_ctrl
  import lb_pkg::*;
(
  input  logic     shift_i,
  input  logic     recirc_i,
  output logic     adv_o,
  output lb_mode_e mode_o
);
  always_comb begin
    adv_o  = shift_i;
    mode_o = recirc_i ? LB_RECIRC : LB_LOAD;
  end
endmodule

// File: rtl/lb_shift_lane.sv
module lb_shift_lane
  import lb_pkg::*;
#(
  parameter int DEPTH = 80  // must be >= 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     adv_i,
  input  lb_mode_e mode_i,
  input  logic     din_i,
  output logic     tap_o
);
  logic [DEPTH-1:0] stg_q;
  logic             feed;

  always_comb feed = (mode_i == LB_RECIRC) ? stg_q[DEPTH-1] : din_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    stg_q <= '0;
    else if (adv_i) stg_q <= {stg_q[DEPTH-2:0], feed};
  end

  assign tap_o = stg_q[DEPTH-1];

  AST_LOAD_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && mode_i == LB_LOAD) |=> stg_q[0] == $past(din_i)); // R2
  AST_RECIRC_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && mode_i == LB_RECIRC) |=> stg_q[0] == $past(stg_q[DEPTH-1])); // R3
  AST_STATIC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(stg_q)); // R4
endmodule

// File: rtl/lb_bus_drive.sv
module lb_bus_drive #(
  parameter int W        = 8,
  parameter bit HAS_OSEL = 1'b1
) (
  input  logic [W-1:0] data_i,
  input  logic         osel_i,
  output logic [W-1:0] data_o,
  output logic         oe_o
);
  assign data_o = data_i;
  generate
    if (HAS_OSEL) begin : g_osel
      assign oe_o = ~osel_i;
    end else begin : g_fixed
      logic unused_osel;
      assign unused_osel = osel_i;
      assign oe_o = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/lb_line_buffer.sv
module lb_line_buffer
  import lb_pkg::*;
#(
  parameter int NUM_LANES = 8,
  parameter int DEPTH     = 80,
  parameter bit HAS_OSEL  = 1'b1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 shift_i,
  input  logic                 recirc_i,
  input  logic                 osel_i,
  input  logic [NUM_LANES-1:0] data_i,
  output logic [NUM_LANES-1:0] data_o,
  output logic                 oe_o
);
  logic                 adv;
  lb_mode_e             mode;
  logic [NUM_LANES-1:0] tap;

  lb_ctrl i_ctrl (
    .shift_i (shift_i),
    .recirc_i(recirc_i),
    .adv_o   (adv),
    .mode_o  (mode)
  );

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    lb_shift_lane #(.DEPTH(DEPTH)) i_lane (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .adv_i (adv),
      .mode_i(mode),
      .din_i (data_i[k]),
      .tap_o (tap[k])
    );
  end

  lb_bus_drive #(.W(NUM_LANES), .HAS_OSEL(HAS_OSEL)) i_drive (
    .data_i(tap),
    .osel_i(osel_i),
    .data_o(data_o),
    .oe_o  (oe_o)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> data_o == '0); // R1
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(data_o)); // R4

  if (HAS_OSEL) begin : g_ast_osel
    AST_BUS_RELEASE: assert property (@(posedge clk_i)
      osel_i |-> !oe_o); // R5
    AST_BUS_DRIVE: assert property (@(posedge clk_i)
      !osel_i |-> oe_o); // R5
  end else begin : g_ast_fixed
    AST_ALWAYS_DRIVEN: assert property (@(posedge clk_i)
      osel_i |-> oe_o); // R7
  end
endmodule

// File: tb/test_lb_line_buffer.sv
module test_lb_line_buffer;
  localparam int W  = 8;
  localparam int D  = 80;
  localparam int DS = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic shift_i = 1'b0, recirc_i = 1'b0, osel_i = 1'b0;
  logic [W-1:0] data_i = '0;
  logic [W-1:0] data_o;
  logic oe_o;

  logic shift_s = 1'b0, osel_s = 1'b0;
  logic [W-1:0] din_s = '0;
  logic [W-1:0] dout_s;
  logic oe_s;

  int checks = 0;
  int failures = 0;
  logic [W-1:0] ref_q [D];

  always #5 clk_i = ~clk_i;

  lb_line_buffer #(.NUM_LANES(W), .DEPTH(D), .HAS_OSEL(1'b1)) i_lb_line_buffer (
    .clk_i, .rst_ni, .shift_i, .recirc_i, .osel_i, .data_i, .data_o, .oe_o);

  lb_line_buffer #(.NUM_LANES(W), .DEPTH(DS), .HAS_OSEL(1'b0)) i_small (
    .clk_i, .rst_ni, .shift_i(shift_s), .recirc_i(1'b0), .osel_i(osel_s),
    .data_i(din_s), .data_o(dout_s), .oe_o(oe_s));

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic ref_shift(input logic rc, input logic [W-1:0] d);
    logic [W-1:0] fb;
    fb = rc ? ref_q[D-1] : d;
    for (int i = D-1; i > 0; i--) ref_q[i] = ref_q[i-1];
    ref_q[0] = fb;
  endtask

  // one shift, inputs set at negedge, checked 2 ns after the edge
  task automatic step(input logic rc, input logic [W-1:0] d, input logic os, input string req);
    @(negedge clk_i);
    shift_i = 1'b1; recirc_i = rc; data_i = d; osel_i = os;
    #1;
    chk(oe_o == !os, "R5", {7'b0, oe_o}, {7'b0, !os});
    @(posedge clk_i);
    ref_shift(rc, d);
    #2;
    chk(data_o == ref_q[D-1], req, data_o, ref_q[D-1]);
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [W-1:0] first, held;
    for (int i = 0; i < D; i++) ref_q[i] = '0;
    // R1/R5: reset state, enable follows osel during reset
    #12;
    chk(data_o == 8'h00, "R1", data_o, 8'h00);
    chk(oe_o == 1'b1, "R5", {7'b0, oe_o}, 8'h01);
    osel_i = 1'b1; #1;
    chk(oe_o == 1'b0, "R5", {7'b0, oe_o}, 8'h00);
    osel_i = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;

    // R2: load a full row
    for (int i = 0; i < D; i++) begin
      logic [W-1:0] b;
      b = 8'($urandom);
      if (i == 0) first = b;
      step(1'b0, b, 1'b0, "R2");
    end
    chk(data_o == first, "R2", data_o, first);

    // R3/R6: recirculate several passes, random data_i and osel toggling
    for (int p = 0; p < 3; p++) begin
      for (int i = 0; i < D; i++) step(1'b1, 8'($urandom), 1'($urandom), "R3");
      chk(data_o == first, "R3", data_o, first);
    end

    // R8: walking-one lane isolation via partial reload then rotation
    for (int i = 0; i < W; i++) step(1'b0, 8'(1 << i), 1'b0, "R8");
    for (int i = 0; i < 2 * D; i++) step(1'b1, 8'hFF, 1'($urandom), "R8");

    // R4: hold while shift low
    @(negedge clk_i); shift_i = 1'b0;
    held = data_o;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i);
      data_i = 8'($urandom); recirc_i = 1'($urandom);
      chk(data_o == held, "R4", data_o, held);
    end
    for (int i = 0; i < D; i++) step(1'b1, 8'($urandom), 1'b0, "R4");

    // mixed: short reload mid-row then rotation (R2/R3)
    for (int i = 0; i < 17; i++) step(1'b0, 8'($urandom), 1'($urandom), "R2");
    for (int i = 0; i < D + 5; i++) step(1'b1, 8'($urandom), 1'($urandom), "R3");

    // R1: asynchronous reset mid-run, then row reads zero
    @(negedge clk_i); shift_i = 1'b0; #2;
    rst_ni = 1'b0; #1;
    chk(data_o == 8'h00, "R1", data_o, 8'h00);
    @(negedge clk_i); rst_ni = 1'b1;
    for (int i = 0; i < D; i++) ref_q[i] = '0;
    for (int i = 0; i < D; i++) step(1'b1, 8'hA5, 1'b0, "R1");

    @(negedge clk_i); shift_i = 1'b0;

    // R7: small build without release control, exhaustive byte sweep
    for (int v = 0; v < 256; v++) begin
      @(negedge clk_i);
      shift_s = 1'b1; din_s = 8'(v); osel_s = 1'(v);
      #1;
      chk(oe_s == 1'b1, "R7", {7'b0, oe_s}, 8'h01);
      @(posedge clk_i); #2;
      if (v >= DS - 1)
        chk(dout_s == 8'(v - (DS - 1)), "R2", dout_s, 8'(v - (DS - 1)));
      else
        chk(dout_s == 8'h00, "R1", dout_s, 8'h00);
    end
    @(negedge clk_i); shift_s = 1'b0;

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule